// File: doc/BRIEF.md
# Broadcast Control Word Address Filter

Each cluster node of an on-chip test-control network hears every control word that the central scheduler puts on the shared channel. This filter sits on the receive side of one node. It decides whether a word is meant for that node and, if so, hands the payload to the core wrappers attached to the node. Words for other nodes are dropped and leave no trace.

A word has a destination byte above a payload. When the top bit of the destination is clear, the low seven bits name one node, and only the node holding that ID takes the word. When the top bit is set, the low seven bits name a group. Every node whose membership mask has that group's bit set takes the word. Several cores can therefore start testing in the same cycle. Group number 127 with the flag set is a broadcast that every node takes. The node ID and the membership mask are set from configuration inputs while reset is held.

Top module: `node_addr_filter`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, acc_o is 0 and payload_o is all zeros.
- R2: A valid word with word_i[23] = 0 and word_i[22:16] equal to the captured node ID is accepted: one clock later acc_o is 1 and payload_o equals word_i[15:0] of that word.
- R3: A valid word with word_i[23] = 0 and word_i[22:16] different from the node ID is dropped. One clock later acc_o is 0 and payload_o still holds its previous value.
- R4: A valid word with word_i[23] = 1 and group g = word_i[22:16] in the range 0..126 is accepted exactly when bit g of the captured membership mask is 1. Otherwise it is dropped as in R3.
- R5: A valid word with word_i[23:16] = 8'hFF is accepted whatever the mask and node ID hold.
- R6: With valid_i low, acc_o is 0 one clock later and payload_o is unchanged, whatever word_i holds.
- R7: Each accepted word gives a one-cycle acc_o pulse exactly one clock after its valid cycle. Words sent on back-to-back cycles each give their own pulse and payload.
- R8: node_id_cfg_i and grp_mask_cfg_i are sampled only while rst_ni is low. Changing them after reset has no effect on which words are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; the configuration is sampled while it is low |
| node_id_cfg_i | input | 7 | This node's unique ID |
| grp_mask_cfg_i | input | 128 | Group membership mask; bit g set means the node is in group g |
| valid_i | input | 1 | A control word is present on word_i |
| word_i | input | 24 | Control word: bit 23 is the multicast flag, bits 22:16 are the ID or group, bits 15:0 are the payload |
| acc_o | output | 1 | One-cycle strobe for an accepted word |
| payload_o | output | 16 | Payload of the last accepted word |

## Verification
The hardest case to reach is the link between the configuration captured during reset and the decision made long after it. A wrong node ID or a wrong mask bit shows up only for the one destination that hits it. The configuration inputs can also change after reset, and that has to stay invisible. For each of several contrasting ID and mask setups, the stimulus sweeps all 256 destination bytes back to back. It then changes the configuration inputs while the node runs and sends words to the old and new IDs and groups. A design that samples the configuration late or still follows it is caught this way.

// File: rtl/naf_pkg.sv
`timescale 1ns/1ps
package naf_pkg;
  typedef enum logic [1:0] {
    KIND_UNI = 2'd0,
    KIND_GRP = 2'd1,
    KIND_ALL = 2'd2
  } dest_kind_e;

  function automatic dest_kind_e classify(input logic mc, input logic grp_all);
    if (!mc) return KIND_UNI;
    if (grp_all) return KIND_ALL;
    return KIND_GRP;
  endfunction
endpackage

// File: rtl/naf_cfg_regs.sv
`timescale 1ns/1ps
module naf_cfg_regs #(
  parameter int GRP_W   = 7,
  parameter int NUM_GRP = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GRP_W-1:0]   id_cfg_i,
  input  logic [NUM_GRP-1:0] mask_cfg_i,
  output logic [GRP_W-1:0]   id_o,
  output logic [NUM_GRP-1:0] mask_o
);
  logic [GRP_W-1:0]   id_q;
  logic [NUM_GRP-1:0] mask_q;

  // capture only while held in reset, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      id_q   <= id_cfg_i;
      mask_q <= mask_cfg_i;
    end
  end

  assign id_o   = id_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/naf_match.sv
`timescale 1ns/1ps
module naf_match
  import naf_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int NUM_GRP  = 128,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic [ID_W-1:0]    dest_i,
  input  logic [ID_W-2:0]    own_id_i,
  input  logic [NUM_GRP-1:0] mask_i,
  output logic               hit_o
);
  localparam int GRP_W = ID_W - 1;

  logic [GRP_W-1:0] grp;
  logic             grp_bit;
  logic             all_hit;
  dest_kind_e       kind;

  assign grp     = dest_i[GRP_W-1:0];
  assign grp_bit = mask_i[grp];
  assign kind    = classify(dest_i[ID_W-1], &grp);

  generate
    if (BCAST_EN) begin : g_bcast
      assign all_hit = 1'b1;
    end else begin : g_no_bcast
      assign all_hit = grp_bit;
    end
  endgenerate

  always_comb begin
    unique case (kind)
      KIND_UNI: hit_o = (grp == own_id_i);
      KIND_GRP: hit_o = grp_bit;
      KIND_ALL: hit_o = all_hit;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/naf_out_reg.sv
`timescale 1ns/1ps
module naf_out_reg #(
  parameter int PAYLOAD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  output logic                 acc_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= 1'b0;
      payload_o <= '0;
    end else begin
      acc_o <= load_i;
      if (load_i) payload_o <= data_i;
    end
  end
endmodule

// File: rtl/node_addr_filter.sv
`timescale 1ns/1ps
module node_addr_filter #(
  parameter int ID_W      = 8,
  parameter int PAYLOAD_W = 16,
  parameter bit BCAST_EN  = 1'b1,
  localparam int GRP_W    = ID_W - 1,
  localparam int NUM_GRP  = 1 << GRP_W,
  localparam int WORD_W   = ID_W + PAYLOAD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [GRP_W-1:0]     node_id_cfg_i,
  input  logic [NUM_GRP-1:0]   grp_mask_cfg_i,
  input  logic                 valid_i,
  input  logic [WORD_W-1:0]    word_i,
  output logic                 acc_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  logic [GRP_W-1:0]   own_id;
  logic [NUM_GRP-1:0] own_mask;
  logic               hit;

  naf_cfg_regs #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_cfg_i   (node_id_cfg_i),
    .mask_cfg_i (grp_mask_cfg_i),
    .id_o       (own_id),
    .mask_o     (own_mask)
  );

  naf_match #(.ID_W(ID_W), .NUM_GRP(NUM_GRP), .BCAST_EN(BCAST_EN)) u_match (
    .dest_i   (word_i[WORD_W-1:PAYLOAD_W]),
    .own_id_i (own_id),
    .mask_i   (own_mask),
    .hit_o    (hit)
  );

  naf_out_reg #(.PAYLOAD_W(PAYLOAD_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (valid_i & hit),
    .data_i    (word_i[PAYLOAD_W-1:0]),
    .acc_o     (acc_o),
    .payload_o (payload_o)
  );
endmodule

// File: rtl/naf_filter_chk.sv
`timescale 1ns/1ps
module naf_filter_chk #(
  parameter int ID_W      = 8,
  parameter int PAYLOAD_W = 16,
  parameter bit BCAST_EN  = 1'b1,
  localparam int GRP_W    = ID_W - 1,
  localparam int NUM_GRP  = 1 << GRP_W,
  localparam int WORD_W   = ID_W + PAYLOAD_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [GRP_W-1:0]     node_id_cfg_i,
  input logic [NUM_GRP-1:0]   grp_mask_cfg_i,
  input logic                 valid_i,
  input logic [WORD_W-1:0]    word_i,
  input logic                 acc_o,
  input logic [PAYLOAD_W-1:0] payload_o
);
  logic [GRP_W-1:0]   ref_id;
  logic [NUM_GRP-1:0] ref_mask;
  logic               ref_ok;
  logic               mc;
  logic [GRP_W-1:0]   dst;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ref_id   <= node_id_cfg_i;
      ref_mask <= grp_mask_cfg_i;
      ref_ok   <= 1'b1;
    end
  end

  assign mc  = word_i[WORD_W-1];
  assign dst = word_i[WORD_W-2:PAYLOAD_W];

  AST_NO_ACC_WO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> $past(valid_i)); // R6
  AST_HOLD_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_o |-> $stable(payload_o)); // R3
  AST_ACC_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> payload_o == $past(word_i[PAYLOAD_W-1:0])); // R7
  AST_UNI_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok && valid_i && !mc && dst == ref_id) |=> acc_o); // R2
  AST_UNI_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok && valid_i && !mc && dst != ref_id) |=> !acc_o); // R3
  AST_GRP_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok && valid_i && mc && !(&dst)) |=> acc_o == $past(ref_mask[dst])); // R4
  AST_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BCAST_EN && valid_i && mc && (&dst)) |=> acc_o); // R5
endmodule

bind node_addr_filter naf_filter_chk #(
  .ID_W(ID_W), .PAYLOAD_W(PAYLOAD_W), .BCAST_EN(BCAST_EN)
) u_chk (.*);

// File: tb/sim_node_addr_filter.sv
`timescale 1ns/1ps
module sim_node_addr_filter;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [6:0]   node_id_cfg_i;
  logic [127:0] grp_mask_cfg_i;
  logic         valid_i;
  logic [23:0]  word_i;
  logic         acc_o;
  logic [15:0]  payload_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [6:0]   m_id;
  logic [127:0] m_mask;
  logic [15:0]  m_pl;

  always #2.5 clk_i = ~clk_i;

  node_addr_filter u0 (.*);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at a negedge, check at the next negedge (one register between)
  task automatic send(input logic v, input logic [7:0] dest, input logic [15:0] pl);
    logic  e_acc;
    string tag;
    valid_i = v;
    word_i  = {dest, pl};
    if (!v) begin
      e_acc = 1'b0; tag = "R6";
    end else if (!dest[7]) begin
      e_acc = (dest[6:0] == m_id); tag = e_acc ? "R2" : "R3";
    end else if (&dest[6:0]) begin
      e_acc = 1'b1; tag = "R5";
    end else begin
      e_acc = m_mask[dest[6:0]]; tag = "R4";
    end
    if (e_acc) m_pl = pl;
    @(negedge clk_i);
    check(acc_o == e_acc, tag, {31'd0, acc_o}, {31'd0, e_acc});
    check(payload_o == m_pl, e_acc ? "R7" : tag, {16'd0, payload_o}, {16'd0, m_pl});
  endtask

  task automatic do_reset(input logic [6:0] id, input logic [127:0] mask);
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    node_id_cfg_i = id;
    grp_mask_cfg_i = mask;
    m_id = id; m_mask = mask; m_pl = '0;
    repeat (3) @(negedge clk_i);
    check(acc_o == 1'b0 && payload_o == 16'd0, "R1", {15'd0, acc_o, payload_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(acc_o == 1'b0 && payload_o == 16'd0, "R1", {15'd0, acc_o, payload_o}, 32'd0);
  endtask

  function automatic logic [127:0] mk_mask(input int k);
    logic [127:0] m = '0;
    for (int g = 0; g < 128; g++) begin
      case (k)
        1: m[g] = 1'b1;
        2: m[g] = (g % 3 == 0);
        3: m[g] = (g == 0 || g == 64 || g == 126);
        default: m[g] = 1'b0;
      endcase
    end
    return m;
  endfunction

  initial begin
    rst_ni = 1'b0;
    valid_i = 1'b0;
    word_i = '0;
    node_id_cfg_i = '0;
    grp_mask_cfg_i = '0;
    for (int k = 0; k < 4; k++) begin
      logic [6:0] id;
      id = 7'((k * 37 + 5) % 128);
      if (k == 1) id = 7'd127;
      do_reset(id, mk_mask(k));
      // full destination sweep, back to back
      for (int d = 0; d < 256; d++)
        send(1'b1, 8'(d), 16'((d * 251 + k * 97) ^ 16'hA5C3));
      // valid low on words that would hit (R6)
      send(1'b0, {1'b0, m_id}, 16'h1111);
      send(1'b0, 8'hFF, 16'h2222);
      // R8: configuration changes after reset are ignored
      node_id_cfg_i = m_id + 7'd1;
      grp_mask_cfg_i = ~m_mask;
      @(negedge clk_i);
      send(1'b1, {1'b0, m_id + 7'd1}, 16'h3333);
      send(1'b1, {1'b0, m_id}, 16'h4444);
      send(1'b1, 8'h80, 16'h5555);
      send(1'b1, 8'hC0, 16'h6666);
      // R8 explicit: accepted payload after cfg change still follows old ID
      check(payload_o == 16'h4444 || m_mask[0] || m_mask[64], "R8",
            {16'd0, payload_o}, 32'h4444);
      valid_i = 1'b0;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule